// File: doc/BRIEF.md
# Sync Pulse Timing Error Classifier

This block watches one sampled serial bus line, where a logic 1 is the dominant level. It measures how long each dominant pulse lasts and how many clock ticks have passed since the last accepted sync pulse. From these two values it sorts the pulse into one of several classes: a normal sync, an alarm sync, a short pulse that is ignored, a message format error or an illegal pulse. A cycle timer also reports a lost sync when no valid sync pulse arrives in time. Each error kind sets its own sticky flag. An interrupt is raised when a set flag has its enable bit set.

The block keeps a synchronized state and a transmit/receive permission output, which the surrounding controller uses to gate traffic. A pulse with a valid sync length resynchronizes the node even when it arrives too early. A format error only pauses traffic for a short idle time. An illegal pulse or a lost sync drops synchronization until the next correct sync pulse. While the local transmitter is active, and for a hold time after it stops, the line that is measured comes from the local transmit signal and not from the bus. This keeps the node from receiving its own echoes.

All limits are parameters counted in clock ticks. The pulse length is decided on the clock edge where the measured line is first seen recessive again. The cycle timer restarts from zero at that edge whenever a sync pulse is accepted.

Top module: `sync_pulse_classifier`

## Requirements
- R1: After reset, err_flags_o is 0, irq_o is 0, synced_o is 0, txrx_ok_o is 0 and sync_pulse_o is 0.
- R2: A pulse of length L ticks is a valid sync when SYN_A_MIN < L < SYN_A_MAX (alarm) or SYN_N_MIN < L < SYN_N_MAX (normal). Lengths equal to a window limit are not valid. On the edge that ends a valid sync pulse, sync_pulse_o goes high for one cycle, alarm_o shows whether it was an alarm sync, synced_o becomes 1 and the cycle timer restarts.
- R3: While unsynchronized, any pulse that is not a valid sync is ignored. No flag is set and synced_o stays 0.
- R4: A valid sync that ends while synchronized and before EARLY_LIM = CYC_MIN - SYN_N_MAX ticks since the last accepted sync sets the too-early flag (bit 1). It is still accepted as the new sync point.
- R5: Before EARLY_LIM, a pulse with START_SEQ < L <= SYN_A_MIN sets the format flag (bit 0). synced_o stays 1, and txrx_ok_o is held low for IDLE_MIN cycles before it returns high.
- R6: Before EARLY_LIM, a pulse with L > SYN_A_MIN that is not a valid sync (a gap length or a length above SYN_N_MAX) sets the illegal flag (bit 3) and clears synced_o and txrx_ok_o.
- R7: At or after EARLY_LIM, any pulse that is not a valid sync, short pulses included, sets the illegal flag (bit 3) and clears synced_o.
- R8: When CYC_MAX ticks pass after the last accepted sync with no new valid sync, the lost flag (bit 2) is set and synced_o is cleared.
- R9: Flags are sticky. A 1 on bit i of err_clr_i clears flag i. If an event sets a flag in the same cycle that it is cleared, the set wins.
- R10: irq_o is high exactly when some flag i and err_en_i[i] are both 1.
- R11: While tx_active_i is 1, and for ECHO_BITS*BIT_TICKS cycles after it falls, the measured line is tx_dom_i instead of bus_dom_i.
- R12: Before EARLY_LIM, a pulse with L <= START_SEQ sets no flag and leaves synced_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_dom_i | input | 1 | Sampled bus line, 1 = dominant |
| tx_active_i | input | 1 | Local transmitter is busy |
| tx_dom_i | input | 1 | Local transmit line, 1 = dominant |
| err_en_i | input | 4 | Interrupt enable per flag |
| err_clr_i | input | 4 | Clear per flag (write 1 to clear) |
| err_flags_o | output | 4 | Sticky flags: 0 format, 1 too early, 2 lost, 3 illegal |
| irq_o | output | 1 | Interrupt request |
| synced_o | output | 1 | Node is synchronized |
| txrx_ok_o | output | 1 | Transmit and receive allowed |
| sync_pulse_o | output | 1 | One-cycle strobe when a sync pulse is accepted |
| alarm_o | output | 1 | Last accepted sync was an alarm sync |

## Verification
The assertions check several rules on every cycle:
- Flags never drop unless their clear bit is set.
- The interrupt only appears while some flag is set.
- Permission to transmit and receive implies synchronization.
- The rise of the lost or illegal flag always comes with loss of sync.
- A too-early flag always comes with an accepted sync strobe.
- The cycle timer stays within its limit.
- The echo hold is armed when the transmitter stops.

Only the bench scenarios can show the rest:
- The exact length windows, including the boundary lengths.
- The split of the cycle into an early part and a late part.
- The length of the idle pause.
- The tick at which a lost sync is declared.
- Which of the two lines is measured while the echo hold is running.

// File: rtl/spc_pkg.sv
package spc_pkg;
  localparam int NUM_ERR = 4;
  localparam int F_FORMAT  = 0;
  localparam int F_EARLY   = 1;
  localparam int F_LOST    = 2;
  localparam int F_ILLEGAL = 3;

  typedef enum logic [2:0] {
    PC_NONE,
    PC_SYNC_N,
    PC_SYNC_A,
    PC_FORMAT,
    PC_ILLEGAL
  } pulse_cls_e;
endpackage

// File: rtl/spc_echo_mux.sv
module spc_echo_mux #(
  parameter int HOLD_TICKS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_dom_i,
  input  logic tx_active_i,
  input  logic tx_dom_i,
  output logic line_o
);
  localparam int HW = $clog2(HOLD_TICKS + 1);
  localparam logic [HW-1:0] HOLD_L = HW'(HOLD_TICKS);

  logic [HW-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                hold_q <= '0;
    else if (tx_active_i)       hold_q <= HOLD_L;
    else if (hold_q != '0)      hold_q <= hold_q - 1'b1;
  end

  assign line_o = (tx_active_i || hold_q != '0) ? tx_dom_i : bus_dom_i;

  assert_echo_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_active_i) |-> hold_q == HOLD_L);
endmodule

// File: rtl/spc_pulse_meter.sv
module spc_pulse_meter #(
  parameter int LEN_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_i,
  output logic             end_o,
  output logic [LEN_W-1:0] len_o
);
  localparam logic [LEN_W-1:0] SAT = '1;

  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (line_i)      cnt_q <= (cnt_q == SAT) ? cnt_q : cnt_q + 1'b1;
    else                  cnt_q <= '0;
  end

  // pulse is judged on the first recessive tick
  assign end_o = !line_i && (cnt_q != '0);
  assign len_o = cnt_q;

  assert_len_sat_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_i && cnt_q == SAT) |=> cnt_q == SAT);
endmodule

// File: rtl/spc_classifier.sv
module spc_classifier
  import spc_pkg::*;
#(
  parameter int LEN_W     = 5,
  parameter int START_SEQ = 3,
  parameter int SYN_A_MIN = 10,
  parameter int SYN_A_MAX = 14,
  parameter int SYN_N_MIN = 20,
  parameter int SYN_N_MAX = 24
) (
  input  logic [LEN_W-1:0] len_i,
  input  logic             early_i,
  input  logic             synced_i,
  output pulse_cls_e       cls_o
);
  localparam logic [LEN_W-1:0] L_SS  = LEN_W'(START_SEQ);
  localparam logic [LEN_W-1:0] L_AMN = LEN_W'(SYN_A_MIN);
  localparam logic [LEN_W-1:0] L_AMX = LEN_W'(SYN_A_MAX);
  localparam logic [LEN_W-1:0] L_NMN = LEN_W'(SYN_N_MIN);
  localparam logic [LEN_W-1:0] L_NMX = LEN_W'(SYN_N_MAX);

  logic in_alarm, in_normal;
  assign in_alarm  = (len_i > L_AMN) && (len_i < L_AMX);
  assign in_normal = (len_i > L_NMN) && (len_i < L_NMX);

  always_comb begin
    if (in_normal)              cls_o = PC_SYNC_N;
    else if (in_alarm)          cls_o = PC_SYNC_A;
    else if (!synced_i)         cls_o = PC_NONE;
    else if (!early_i)          cls_o = PC_ILLEGAL;
    else if (len_i <= L_SS)     cls_o = PC_NONE;
    else if (len_i <= L_AMN)    cls_o = PC_FORMAT;
    else                        cls_o = PC_ILLEGAL;
  end
endmodule

// File: rtl/sync_pulse_classifier.sv
module sync_pulse_classifier
  import spc_pkg::*;
#(
  parameter int BIT_TICKS = 2,
  parameter int ECHO_BITS = 8,
  parameter int START_SEQ = 3,
  parameter int SYN_A_MIN = 10,
  parameter int SYN_A_MAX = 14,
  parameter int SYN_N_MIN = 20,
  parameter int SYN_N_MAX = 24,
  parameter int CYC_MIN   = 100,
  parameter int CYC_MAX   = 150,
  parameter int IDLE_MIN  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_dom_i,
  input  logic               tx_active_i,
  input  logic               tx_dom_i,
  input  logic [NUM_ERR-1:0] err_en_i,
  input  logic [NUM_ERR-1:0] err_clr_i,
  output logic [NUM_ERR-1:0] err_flags_o,
  output logic               irq_o,
  output logic               synced_o,
  output logic               txrx_ok_o,
  output logic               sync_pulse_o,
  output logic               alarm_o
);
  localparam int LEN_W     = $clog2(SYN_N_MAX + 2);
  localparam int CYC_W     = $clog2(CYC_MAX + 1);
  localparam int IDLE_W    = $clog2(IDLE_MIN + 1);
  localparam int EARLY_LIM = CYC_MIN - SYN_N_MAX;
  localparam logic [CYC_W-1:0]  CYC_MAX_L = CYC_W'(CYC_MAX);
  localparam logic [CYC_W-1:0]  EARLY_L   = CYC_W'(EARLY_LIM);
  localparam logic [IDLE_W-1:0] IDLE_L    = IDLE_W'(IDLE_MIN);

  logic             line;
  logic             pulse_end;
  logic [LEN_W-1:0] pulse_len;
  pulse_cls_e       cls;

  logic [CYC_W-1:0]   cyc_q;
  logic [IDLE_W-1:0]  idle_q;
  logic               synced_q, sync_pulse_q, alarm_q;
  logic [NUM_ERR-1:0] flags_q, flag_set;
  logic               early, accept, lost_evt, illegal_evt, format_evt;

  spc_echo_mux #(.HOLD_TICKS(ECHO_BITS * BIT_TICKS)) u_echo (
    .clk_i, .rst_ni, .bus_dom_i, .tx_active_i, .tx_dom_i, .line_o(line)
  );

  spc_pulse_meter #(.LEN_W(LEN_W)) u_meter (
    .clk_i, .rst_ni, .line_i(line), .end_o(pulse_end), .len_o(pulse_len)
  );

  spc_classifier #(
    .LEN_W(LEN_W), .START_SEQ(START_SEQ),
    .SYN_A_MIN(SYN_A_MIN), .SYN_A_MAX(SYN_A_MAX),
    .SYN_N_MIN(SYN_N_MIN), .SYN_N_MAX(SYN_N_MAX)
  ) u_cls (
    .len_i(pulse_len), .early_i(early), .synced_i(synced_q), .cls_o(cls)
  );

  assign early       = cyc_q < EARLY_L;
  assign accept      = pulse_end && (cls == PC_SYNC_N || cls == PC_SYNC_A);
  assign format_evt  = pulse_end && cls == PC_FORMAT;
  assign illegal_evt = pulse_end && cls == PC_ILLEGAL;
  assign lost_evt    = synced_q && (cyc_q == CYC_MAX_L) && !accept;

  always_comb begin
    flag_set            = '0;
    flag_set[F_FORMAT]  = format_evt;
    flag_set[F_EARLY]   = accept && synced_q && early;
    flag_set[F_LOST]    = lost_evt;
    flag_set[F_ILLEGAL] = illegal_evt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q        <= '0;
      synced_q     <= 1'b0;
      idle_q       <= '0;
      flags_q      <= '0;
      sync_pulse_q <= 1'b0;
      alarm_q      <= 1'b0;
    end else begin
      sync_pulse_q <= accept;
      flags_q      <= (flags_q & ~err_clr_i) | flag_set;
      if (accept) alarm_q <= (cls == PC_SYNC_A);

      if (accept)                             cyc_q <= '0;
      else if (!synced_q)                     cyc_q <= '0;
      else if (cyc_q != CYC_MAX_L)            cyc_q <= cyc_q + 1'b1;

      if (accept)                             synced_q <= 1'b1;
      else if (lost_evt || illegal_evt)       synced_q <= 1'b0;

      if (accept)                             idle_q <= '0;
      else if (format_evt)                    idle_q <= IDLE_L;
      else if (idle_q != '0)                  idle_q <= idle_q - 1'b1;
    end
  end

  assign err_flags_o  = flags_q;
  assign irq_o        = |(flags_q & err_en_i);
  assign synced_o     = synced_q;
  assign txrx_ok_o    = synced_q && (idle_q == '0);
  assign sync_pulse_o = sync_pulse_q;
  assign alarm_o      = alarm_q;

  assert_flag_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(err_flags_o) & ~$past(err_clr_i)) & ~err_flags_o) == '0));
  assert_irq_source_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (err_flags_o != '0));
  assert_txrx_needs_sync_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txrx_ok_o |-> synced_o);
  assert_lost_desync_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_flags_o[F_LOST]) |-> !synced_o);
  assert_illegal_desync_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_flags_o[F_ILLEGAL]) |-> !synced_o);
  assert_early_resync_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_flags_o[F_EARLY]) |-> (sync_pulse_o && synced_o));
  assert_cyc_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_q <= CYC_MAX_L);
endmodule

// File: tb/tb_sync_pulse_classifier.sv
`timescale 1ns/1ps
module tb_sync_pulse_classifier;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_dom = 1'b0, tx_active = 1'b0, tx_dom = 1'b0;
  logic [3:0] err_en = '0, err_clr = '0;
  logic [3:0] flags;
  logic irq, synced, txrx_ok, sync_pulse, alarm;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  sync_pulse_classifier dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_dom_i(bus_dom), .tx_active_i(tx_active),
    .tx_dom_i(tx_dom), .err_en_i(err_en), .err_clr_i(err_clr),
    .err_flags_o(flags), .irq_o(irq), .synced_o(synced), .txrx_ok_o(txrx_ok),
    .sync_pulse_o(sync_pulse), .alarm_o(alarm)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_pulse(input int len);
    bus_dom = 1'b1;
    repeat (len) @(negedge clk);
    bus_dom = 1'b0;
    @(negedge clk);
  endtask

  task automatic tx_pulse(input int len);
    tx_dom = 1'b1;
    repeat (len) @(negedge clk);
    tx_dom = 1'b0;
    @(negedge clk);
  endtask

  task automatic clear_all();
    err_clr = 4'hF;
    @(negedge clk);
    err_clr = 4'h0;
  endtask

  task automatic resync();
    bus_pulse(22);
    clear_all();
  endtask

  task automatic t_reset();
    chk("R1 flags", flags, 0);
    chk("R1 irq", irq, 0);
    chk("R1 synced", synced, 0);
    chk("R1 txrx_ok", txrx_ok, 0);
    chk("R1 sync_pulse", sync_pulse, 0);
  endtask

  task automatic t_unsync_ignore();
    bus_pulse(6);  chk("R3 len6 flags", flags, 0);
    bus_pulse(14); chk("R3 len14 boundary not sync", synced, 0);
    bus_pulse(10); chk("R3 len10 boundary not sync", synced, 0);
    bus_pulse(2);  chk("R3 len2 flags", flags, 0);
  endtask

  task automatic t_alarm_sync();
    bus_pulse(12);
    chk("R2 alarm strobe", sync_pulse, 1);
    chk("R2 alarm kind", alarm, 1);
    chk("R2 synced", synced, 1);
    chk("R2 txrx_ok", txrx_ok, 1);
    idle(1);
    chk("R2 strobe one cycle", sync_pulse, 0);
  endtask

  task automatic t_normal_sync();
    idle(90);
    bus_pulse(22);
    chk("R2 normal strobe", sync_pulse, 1);
    chk("R2 normal kind", alarm, 0);
    chk("R2 no flag", flags, 0);
  endtask

  task automatic t_short_ignored();
    bus_pulse(2);
    chk("R12 short flags", flags, 0);
    chk("R12 short synced", synced, 1);
  endtask

  task automatic t_format();
    bus_pulse(6);
    chk("R5 format flag", flags, 4'b0001);
    chk("R5 stays synced", synced, 1);
    chk("R5 txrx blocked", txrx_ok, 0);
    chk("R10 masked irq", irq, 0);
    idle(10);
    chk("R5 txrx restored", txrx_ok, 1);
    chk("R9 flag sticky", flags, 4'b0001);
  endtask

  task automatic t_irq_clear();
    err_en = 4'b0001;
    @(negedge clk);
    chk("R10 irq enabled", irq, 1);
    err_en = 4'b1110;
    @(negedge clk);
    chk("R10 other enables", irq, 0);
    err_en = 4'hF;
    err_clr = 4'b0001;
    @(negedge clk);
    err_clr = 4'b0000;
    chk("R9 clear", flags, 0);
    chk("R10 irq after clear", irq, 0);
  endtask

  task automatic t_too_early();
    bus_pulse(22);
    chk("R4 early flag", flags, 4'b0010);
    chk("R4 accepted", sync_pulse, 1);
    chk("R4 synced", synced, 1);
    chk("R10 irq early", irq, 1);
    clear_all();
    idle(90);
    bus_pulse(22);
    chk("R4 restarted cycle", flags, 0);
  endtask

  task automatic t_early_illegal();
    bus_pulse(17);
    chk("R6 gap flag", flags, 4'b1000);
    chk("R6 gap desync", synced, 0);
    chk("R6 gap txrx", txrx_ok, 0);
    clear_all();
    resync();
    bus_pulse(30);
    chk("R6 long flag", flags, 4'b1000);
    chk("R6 long desync", synced, 0);
    clear_all();
    resync();
  endtask

  task automatic t_late_illegal();
    idle(90);
    bus_pulse(2);
    chk("R7 late flag", flags, 4'b1000);
    chk("R7 late desync", synced, 0);
    clear_all();
    resync();
  endtask

  task automatic t_lost();
    idle(140);
    chk("R8 not yet lost", flags, 0);
    chk("R8 still synced", synced, 1);
    idle(20);
    chk("R8 lost flag", flags, 4'b0100);
    chk("R8 desync", synced, 0);
    clear_all();
    resync();
  endtask

  task automatic t_echo();
    tx_active = 1'b1;
    @(negedge clk);
    bus_pulse(6);
    chk("R11 bus ignored while tx", flags, 0);
    tx_pulse(6);
    chk("R11 tx line measured", flags, 4'b0001);
    clear_all();
    tx_active = 1'b0;
    idle(4);
    bus_pulse(6);
    chk("R11 bus ignored in hold", flags, 0);
    idle(10);
    bus_pulse(6);
    chk("R11 bus after hold", flags, 4'b0001);
    clear_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_unsync_ignore();
    t_alarm_sync();
    t_normal_sync();
    t_short_ignored();
    t_format();
    t_irq_clear();
    t_too_early();
    resync();
    t_early_illegal();
    t_late_illegal();
    t_lost();
    t_echo();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule